// File: doc/BRIEF.md
# Reset Pin Qualifier and Register Initializer

This block sits between the external reset pin of an 8-bit controller core and its register file. It splits the oscillator clock into machine cycles of twelve clocks: six states of two phases each. It looks at the synchronized reset pin at one fixed slot per machine cycle, which is state 5, phase 2. It raises the internal core reset only after that slot has read high in two machine cycles in a row. Pin activity between slots is never seen, so short glitches cannot start a reset.

While the core reset is high, the block supplies the values that the register file loads on every clock:
- all port latches read all ones;
- the stack pointer reads 07H;
- the power-control register is cleared except for one bit, which is carried over from its present value;
- every other special function register is cleared;
- the serial data buffer is handed back its own present contents, so it is left unchanged.

The core reset falls at the first sample slot that reads low. A one-clock release pulse marks that moment.

Top module: `rst_seq`

## Requirements
- R1: A machine cycle is 12 clocks, counted 0 to 11 from the release of `rst_ni`. The pin is qualified only at the clock edge that ends count 9. A two-stage synchronizer sits in front of the qualifier, so that edge acts on the pin level that was captured two clock edges earlier (the edge ending count 7).
- R2: Two consecutive machine cycles whose samples read high raise `core_rst_o` at the second sample edge. After only one high sample, `core_rst_o` stays low.
- R3: A sample that reads low clears the qualification count. The pattern high, low, high across three machine cycles does not raise `core_rst_o`.
- R4: A pin pulse of any length that misses the sampled capture edge has no effect on `core_rst_o`.
- R5: While `core_rst_o` is high, the first sample that reads low drops it at that sample edge. `rst_release_o` is then high for exactly the one following clock.
- R6: `port_init_o` holds 8'hFF in every byte (one byte per port, port 0 in bits 7:0).
- R7: `sp_init_o` is 8'h07.
- R8: `pcon_init_o` bit 4 equals `pcon_cur_i` bit 4, and all its other bits are 0.
- R9: `sfr_init_o` is 8'h00, and `sbuf_init_o` equals `sbuf_cur_i`.
- R10: Driving `rst_ni` low clears `core_rst_o`, `rst_release_o`, the qualification count and the cycle counter at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the sequencer itself |
| rst_pin_i | input | 1 | Raw external reset pin, active high, asynchronous |
| pcon_cur_i | input | 8 | Current power-control register value |
| sbuf_cur_i | input | 8 | Current serial data buffer value |
| core_rst_o | output | 1 | Qualified internal reset |
| rst_release_o | output | 1 | One-clock pulse after internal reset falls |
| port_init_o | output | 32 | Reset value for the four port latches |
| sp_init_o | output | 8 | Reset value for the stack pointer |
| pcon_init_o | output | 8 | Reset value for the power-control register |
| sfr_init_o | output | 8 | Reset value for the remaining special function registers |
| sbuf_init_o | output | 8 | Value the serial buffer keeps through reset |

## Verification
A cycle counter that is off by one or more moves the sample slot. A pin pulse that is timed against the slot is then qualified, or missed, within a single machine cycle, and `core_rst_o` takes the wrong value by the next check. A qualification count that is not cleared, or that saturates wrong, shows up after two or three machine cycles as a reset that arrives early, late or never. A release flag left stuck shows up as a pulse that is longer than one clock, on the clock right after the fall.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;
  localparam int unsigned DATA_W = 8;
  typedef logic [DATA_W-1:0] byte_t;

  localparam byte_t PORT_RST_VAL = 8'hFF;
  localparam byte_t SP_RST_VAL   = 8'h07;
  localparam byte_t SFR_RST_VAL  = 8'h00;
  localparam byte_t PCON_KEEP    = 8'h10;  // bit surviving reset
endpackage

// File: rtl/rst_sync.sv
module rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q[0] <= 1'b0;
        else         chain_q[0] <= d_i;
    end else begin : g_rest
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q[s] <= 1'b0;
        else         chain_q[s] <= chain_q[s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/mc_timer.sv
module mc_timer #(
  parameter int unsigned STATES       = 6,
  parameter int unsigned PHASES       = 2,
  parameter int unsigned SAMPLE_STATE = 5,
  parameter int unsigned SAMPLE_PHASE = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic strobe_o
);
  localparam int unsigned MC_CLKS    = STATES * PHASES;
  localparam int unsigned CNT_W      = $clog2(MC_CLKS);
  localparam int unsigned SAMPLE_IDX = (SAMPLE_STATE - 1) * PHASES + (SAMPLE_PHASE - 1);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(MC_CLKS - 1);
  localparam logic [CNT_W-1:0] SLOT  = CNT_W'(SAMPLE_IDX);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;

  assign strobe_o = (cnt_q == SLOT);
endmodule

// File: rtl/rst_qual.sv
module rst_qual #(
  parameter int unsigned QUAL_CYCLES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  input  logic pin_i,
  output logic core_rst_o,
  output logic release_o
);
  localparam int unsigned HIT_W = $clog2(QUAL_CYCLES + 1);
  localparam logic [HIT_W-1:0] HIT_MAX = HIT_W'(QUAL_CYCLES - 1);

  logic [HIT_W-1:0] hit_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      hit_q      <= '0;
      core_rst_o <= 1'b0;
      release_o  <= 1'b0;
    end else begin
      release_o <= 1'b0;
      if (strobe_i) begin
        if (pin_i) begin
          if (hit_q >= HIT_MAX) core_rst_o <= 1'b1;
          else                  hit_q      <= hit_q + 1'b1;
        end else begin
          hit_q <= '0;
          if (core_rst_o) begin
            core_rst_o <= 1'b0;
            release_o  <= 1'b1;
          end
        end
      end
    end
endmodule

// File: rtl/rst_init.sv
module rst_init
  import rst_seq_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 4
) (
  input  byte_t                       pcon_cur_i,
  input  byte_t                       sbuf_cur_i,
  output logic [NUM_PORTS*DATA_W-1:0] port_init_o,
  output byte_t                       sp_init_o,
  output byte_t                       pcon_init_o,
  output byte_t                       sfr_init_o,
  output byte_t                       sbuf_init_o
);
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    assign port_init_o[p*DATA_W +: DATA_W] = PORT_RST_VAL;
  end

  assign sp_init_o   = SP_RST_VAL;
  assign sfr_init_o  = SFR_RST_VAL;
  assign pcon_init_o = pcon_cur_i & PCON_KEEP;
  assign sbuf_init_o = sbuf_cur_i;
endmodule

// File: rtl/rst_seq.sv
module rst_seq
  import rst_seq_pkg::*;
#(
  parameter int unsigned NUM_PORTS    = 4,
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned QUAL_CYCLES  = 2,
  parameter int unsigned STATES       = 6,
  parameter int unsigned PHASES       = 2,
  parameter int unsigned SAMPLE_STATE = 5,
  parameter int unsigned SAMPLE_PHASE = 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        rst_pin_i,
  input  logic [DATA_W-1:0]           pcon_cur_i,
  input  logic [DATA_W-1:0]           sbuf_cur_i,
  output logic                        core_rst_o,
  output logic                        rst_release_o,
  output logic [NUM_PORTS*DATA_W-1:0] port_init_o,
  output logic [DATA_W-1:0]           sp_init_o,
  output logic [DATA_W-1:0]           pcon_init_o,
  output logic [DATA_W-1:0]           sfr_init_o,
  output logic [DATA_W-1:0]           sbuf_init_o
);
  logic pin_s;
  logic mc_strobe;

  rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (rst_pin_i),
    .q_o    (pin_s)
  );

  mc_timer #(
    .STATES       (STATES),
    .PHASES       (PHASES),
    .SAMPLE_STATE (SAMPLE_STATE),
    .SAMPLE_PHASE (SAMPLE_PHASE)
  ) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strobe_o (mc_strobe)
  );

  rst_qual #(.QUAL_CYCLES(QUAL_CYCLES)) u_qual (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .strobe_i   (mc_strobe),
    .pin_i      (pin_s),
    .core_rst_o (core_rst_o),
    .release_o  (rst_release_o)
  );

  rst_init #(.NUM_PORTS(NUM_PORTS)) u_init (
    .pcon_cur_i  (pcon_cur_i),
    .sbuf_cur_i  (sbuf_cur_i),
    .port_init_o (port_init_o),
    .sp_init_o   (sp_init_o),
    .pcon_init_o (pcon_init_o),
    .sfr_init_o  (sfr_init_o),
    .sbuf_init_o (sbuf_init_o)
  );
endmodule

// File: rtl/rst_seq_chk.sv
module rst_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic strobe,
  input logic pin_s,
  input logic core_rst,
  input logic release_p
);
  // R1: one sample slot per machine cycle
  a_r1_strobe_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe |=> !strobe);

  // R1: core reset moves only at a sample edge
  a_r1_change_at_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(core_rst) |-> $past(strobe));

  // R2: rise needs a high synchronized sample
  a_r2_rise_needs_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(core_rst) |-> $past(pin_s));

  // R5: release pulse is one clock wide
  a_r5_release_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_p |=> !release_p);

  // R5: release only right after the core reset fell
  a_r5_release_after_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_p |-> (!core_rst && $past(core_rst)));
endmodule

bind rst_seq rst_seq_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .strobe    (mc_strobe),
  .pin_s     (pin_s),
  .core_rst  (core_rst_o),
  .release_p (rst_release_o)
);

// File: tb/rst_seq_test.sv
`timescale 1ns/1ps
module rst_seq_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        rst_pin_i = 1'b0;
  logic [7:0]  pcon_cur_i = 8'h00;
  logic [7:0]  sbuf_cur_i = 8'h00;
  logic        core_rst_o, rst_release_o;
  logic [31:0] port_init_o;
  logic [7:0]  sp_init_o, pcon_init_o, sfr_init_o, sbuf_init_o;

  int unsigned cyc = 0;
  int n_vec = 0;
  int n_bad = 0;

  always #2.5 clk_i = ~clk_i;

  always @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) cyc <= 0;
    else         cyc <= cyc + 1;

  rst_seq uut (
    .clk_i, .rst_ni, .rst_pin_i, .pcon_cur_i, .sbuf_cur_i,
    .core_rst_o, .rst_release_o, .port_init_o, .sp_init_o,
    .pcon_init_o, .sfr_init_o, .sbuf_init_o
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_cnt(int unsigned s);
    @(negedge clk_i);
    while ((cyc % 12) != s) @(negedge clk_i);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    rst_pin_i = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic t_reset_state();
    rst_ni = 1'b0;
    #1;
    chk("R10 core_rst in reset", {31'd0, core_rst_o}, 32'd0);
    chk("R10 release in reset", {31'd0, rst_release_o}, 32'd0);
    rst_ni = 1'b1;
  endtask

  task automatic t_qualify();
    wait_cnt(0); rst_pin_i = 1'b1;
    wait_cnt(11);
    chk("R2 one high sample", {31'd0, core_rst_o}, 32'd0);
    wait_cnt(11);
    chk("R2 two high samples", {31'd0, core_rst_o}, 32'd1);
    pcon_cur_i = 8'hFF; sbuf_cur_i = 8'hA5; #1;
    chk("R6 port init", port_init_o, 32'hFFFF_FFFF);
    chk("R7 sp init", {24'd0, sp_init_o}, 32'h07);
    chk("R8 pcon keep bit4 set", {24'd0, pcon_init_o}, 32'h10);
    chk("R9 sfr init", {24'd0, sfr_init_o}, 32'h00);
    chk("R9 sbuf kept", {24'd0, sbuf_init_o}, 32'hA5);
    pcon_cur_i = 8'hEF; sbuf_cur_i = 8'h3C; #1;
    chk("R8 pcon keep bit4 clear", {24'd0, pcon_init_o}, 32'h00);
    chk("R9 sbuf kept 2", {24'd0, sbuf_init_o}, 32'h3C);
    wait_cnt(11);
    chk("R5 stays while high", {31'd0, core_rst_o}, 32'd1);
    wait_cnt(0); rst_pin_i = 1'b0;
    wait_cnt(9);
    chk("R5 held before low sample", {31'd0, core_rst_o}, 32'd1);
    chk("R5 no early pulse", {31'd0, rst_release_o}, 32'd0);
    wait_cnt(10);
    chk("R5 drop at low sample", {31'd0, core_rst_o}, 32'd0);
    chk("R5 release pulse", {31'd0, rst_release_o}, 32'd1);
    @(negedge clk_i);
    chk("R5 release one clock", {31'd0, rst_release_o}, 32'd0);
  endtask

  task automatic t_interrupted();
    wait_cnt(0); rst_pin_i = 1'b1;
    wait_cnt(11);
    chk("R3 first high", {31'd0, core_rst_o}, 32'd0);
    wait_cnt(0); rst_pin_i = 1'b0;
    wait_cnt(11);
    chk("R3 low clears", {31'd0, core_rst_o}, 32'd0);
    wait_cnt(0); rst_pin_i = 1'b1;
    wait_cnt(11);
    chk("R3 high after low", {31'd0, core_rst_o}, 32'd0);
    wait_cnt(0); rst_pin_i = 1'b0;
    wait_cnt(11);
  endtask

  task automatic t_glitch();
    for (int i = 0; i < 4; i++) begin
      wait_cnt(8); rst_pin_i = 1'b1;
      wait_cnt(6); rst_pin_i = 1'b0;
      wait_cnt(11);
      chk("R4 long pulse off slot", {31'd0, core_rst_o}, 32'd0);
    end
    for (int i = 0; i < 3; i++) begin
      wait_cnt(7); rst_pin_i = 1'b1;
      @(negedge clk_i); rst_pin_i = 1'b0;
      wait_cnt(11);
      chk("R1 one-clock pulse on slot", {31'd0, core_rst_o}, (i >= 1) ? 32'd1 : 32'd0);
    end
    wait_cnt(11);
    chk("R1 low slot releases", {31'd0, core_rst_o}, 32'd0);
  endtask

  task automatic t_async_clear();
    wait_cnt(0); rst_pin_i = 1'b1;
    wait_cnt(11); wait_cnt(11);
    chk("R10 precondition", {31'd0, core_rst_o}, 32'd1);
    wait_cnt(3);
    #0.5 rst_ni = 1'b0;
    #0.5;
    chk("R10 async clear", {31'd0, core_rst_o}, 32'd0);
    rst_pin_i = 1'b0;
    @(negedge clk_i); rst_ni = 1'b1;
    wait_cnt(0); rst_pin_i = 1'b1;
    wait_cnt(11);
    chk("R10 count cleared", {31'd0, core_rst_o}, 32'd0);
    rst_pin_i = 1'b0;
    wait_cnt(11);
  endtask

  initial begin
    t_reset_state();
    do_reset();
    t_qualify();
    t_interrupted();
    t_glitch();
    t_async_clear();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule